// File: doc/BRIEF.md
# Byte-Granular Word Copy Engine

This block moves a run of bytes from a source region to a destination region. Either region, or both, may live in a memory that can only be reached with aligned 64-bit word transfers. The other kind of memory is reached one byte at a time. A per-side flag says which kind each side is. Any start address and any length are allowed. The engine walks the transfer one byte per step and keeps a one-word buffer for each word-only side.

On a word-only source, the engine fetches a word only when it first needs a byte from it. It then takes that byte from the lane given by the low address bits. On a word-only destination, the engine first reads the word it is about to change. It drops each byte into its lane and writes the word back once lane 7 has been filled. A word that is still partly filled when the count runs out is written back at the end. Bytes outside the copied range therefore keep their old values.

Software starts a transfer with a one-cycle `start`, which is accepted only while the engine is idle. It then waits for the one-cycle `done` pulse. Both memory ports use a request/acknowledge handshake. The request stays high, with its address and data held steady, until the acknowledge arrives.

Top module: `bwc_engine`

## Requirements
- R1: The byte lane of an address is its low three bits, and the byte of lane L occupies bits L*8+7 down to L*8 of a 64-bit word; a word-only source delivers exactly that byte for each address.
- R2: For a word-only source, one word read is issued for the first byte and one more after each byte taken from lane 7, so the source word-read count equals the number of distinct words the source range touches.
- R3: For a word-only destination, the engine reads each word before placing the first byte of that word. Bytes of that word outside the copied range are left unchanged.
- R4: A byte placed into a destination word replaces only its own 8-bit lane.
- R5: A destination word is written back as soon as a byte lands in lane 7, and the next destination byte begins with a fresh word read.
- R6: A destination word that is partly filled when the count runs out is written back before completion. The destination word-write count therefore equals the number of distinct words the destination range touches.
- R7: A side that is not word-only is accessed through the byte port, with exactly one byte read (source) or byte write (destination) per copied byte, and word writes only ever target the destination.
- R8: A transfer of length zero raises `done` in the cycle after `start` and issues no memory request.
- R9: `done` is a single-cycle pulse that rises only after every write of the transfer has been acknowledged. While it is high, no request is outstanding.
- R10: Source and destination start alignments are independent; any combination of start lanes 0..7 copies correctly.
- R11: A request stays high, with a stable address, until it is acknowledged. Word addresses have their low three bits zero, and the two ports never request in the same cycle.
- R12: A `start` that arrives while the engine is busy is ignored and does not disturb the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a transfer (accepted when idle) |
| src_base | input | AW | First source byte address |
| dst_base | input | AW | First destination byte address |
| byte_count | input | LW | Number of bytes to copy |
| src_wordonly | input | 1 | Source lies in word-only memory |
| dst_wordonly | input | 1 | Destination lies in word-only memory |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| wp_req | output | 1 | Word port request |
| wp_we | output | 1 | Word port write (1) or read (0) |
| wp_addr | output | AW | Word port address, 8-byte aligned |
| wp_wdata | output | 64 | Word port write data |
| wp_ack | input | 1 | Word port acknowledge |
| wp_rdata | input | 64 | Word port read data, valid with ack |
| bp_req | output | 1 | Byte port request |
| bp_we | output | 1 | Byte port write (1) or read (0) |
| bp_addr | output | AW | Byte port address |
| bp_wdata | output | 8 | Byte port write data |
| bp_ack | input | 1 | Byte port acknowledge |
| bp_rdata | input | 8 | Byte port read data, valid with ack |

## Verification
A zero-length `done` is due at the first clock edge after the edge that samples `start`. The bench looks for it at the next falling edge, with no waiting loop. For nonzero lengths, completion time depends on memory latency. The bench therefore polls `done` at falling edges and checks the memory contents and the per-port transaction counts in the cycle `done` is seen, because every write must already have been acknowledged by then. It checks one falling edge later that `done` has dropped and the engine is idle. The memory model acknowledges one edge after a request, and the bench counts transactions at that same edge, so every count is settled before the falling edge where it is compared.

// File: rtl/bwc_pkg.sv
// Shared types for the byte-granular word copy engine.
// Assumes nothing beyond a single clock domain.
package bwc_pkg;

    // Controller states; one request kind per memory-access state.
    typedef enum logic [3:0] {
        S_IDLE,   // waiting for start
        S_STEP,   // decide the next action for the current byte
        S_SRD,    // word read of the source word
        S_SBYTE,  // byte read of the source byte
        S_DST,    // place the held byte into the destination
        S_DRD,    // word read of the destination word (read-modify-write)
        S_DBYTE,  // byte write of the destination byte
        S_DWR,    // word write-back of the destination buffer
        S_DONE    // completion pulse
    } bwc_state_t;

endpackage

// File: rtl/bwc_lane_pick.sv
// Selects one byte lane from a word.
// Assumes WORD_W is a multiple of 8 and the lane index is in range.
module bwc_lane_pick #(
    parameter int WORD_W    = 64,
    parameter int LANE_BITS = 3
) (
    input  logic [WORD_W-1:0]    word_i,
    input  logic [LANE_BITS-1:0] lane_i,
    output logic [7:0]           byte_o
);
    localparam int LANES = WORD_W / 8;

    logic [7:0] lane_arr [LANES];

    // Split the word into its byte lanes.
    for (genvar g = 0; g < LANES; g++) begin : g_split
        assign lane_arr[g] = word_i[g*8 +: 8];
    end

    // Pick the addressed lane.
    assign byte_o = lane_arr[lane_i];

endmodule

// File: rtl/bwc_lane_merge.sv
// Replaces one byte lane of a word and leaves all others as they were.
// Assumes WORD_W is a multiple of 8.
module bwc_lane_merge #(
    parameter int WORD_W    = 64,
    parameter int LANE_BITS = 3
) (
    input  logic [WORD_W-1:0]    word_i,
    input  logic [LANE_BITS-1:0] lane_i,
    input  logic [7:0]           byte_i,
    output logic [WORD_W-1:0]    word_o
);
    localparam int LANES = WORD_W / 8;

    // Each lane is either kept or overwritten by the new byte.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign word_o[g*8 +: 8] = (lane_i == LANE_BITS'(g)) ? byte_i : word_i[g*8 +: 8];
    end

endmodule

// File: rtl/bwc_engine.sv
// Byte-granular copy between byte-addressed and word-only memories.
// Walks the transfer one byte per step. A word-only source is buffered one
// word at a time. A word-only destination is read, merged and written back.
// Assumes both ports answer each request with a one-cycle ack, and that the
// source and destination ranges do not share a word.
module bwc_engine #(
    parameter int AW     = 16,
    parameter int LW     = 16,
    parameter int WORD_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [AW-1:0]     src_base,
    input  logic [AW-1:0]     dst_base,
    input  logic [LW-1:0]     byte_count,
    input  logic              src_wordonly,
    input  logic              dst_wordonly,
    output logic              busy,
    output logic              done,
    output logic              wp_req,
    output logic              wp_we,
    output logic [AW-1:0]     wp_addr,
    output logic [WORD_W-1:0] wp_wdata,
    input  logic              wp_ack,
    input  logic [WORD_W-1:0] wp_rdata,
    output logic              bp_req,
    output logic              bp_we,
    output logic [AW-1:0]     bp_addr,
    output logic [7:0]        bp_wdata,
    input  logic              bp_ack,
    input  logic [7:0]        bp_rdata
);
    import bwc_pkg::*;

    localparam int LANES = WORD_W / 8;
    localparam int LB    = $clog2(LANES);
    localparam logic [LB-1:0] LAST_LANE = LB'(LANES - 1);

    bwc_state_t        state, state_nx;
    logic [AW-1:0]     src_ptr, dst_ptr;
    logic [LW-1:0]     cnt, len_q;
    logic              src_w_q, dst_w_q;
    logic              need_src, need_dst;
    logic [WORD_W-1:0] src_buf, dst_buf, merged;
    logic [7:0]        hold_b, src_pick;
    logic              adv, at_end;

    bwc_lane_pick #(.WORD_W(WORD_W), .LANE_BITS(LB)) u_pick (
        .word_i (src_buf),
        .lane_i (src_ptr[LB-1:0]),
        .byte_o (src_pick)
    );

    bwc_lane_merge #(.WORD_W(WORD_W), .LANE_BITS(LB)) u_merge (
        .word_i (dst_buf),
        .lane_i (dst_ptr[LB-1:0]),
        .byte_i (hold_b),
        .word_o (merged)
    );

    assign at_end = (cnt == len_q);

    // Step to the next byte once the current one has been delivered.
    assign adv = (state == S_DST && dst_w_q && !need_dst && dst_ptr[LB-1:0] != LAST_LANE)
              || (state == S_DBYTE && bp_ack)
              || (state == S_DWR && wp_ack && !at_end);

    // Next-state selection for the copy sequence.
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (start) state_nx = (byte_count == '0) ? S_DONE : S_STEP;
            S_STEP: begin
                if (at_end)          state_nx = (dst_w_q && !need_dst) ? S_DWR : S_DONE;
                else if (!src_w_q)   state_nx = S_SBYTE;
                else if (need_src)   state_nx = S_SRD;
                else                 state_nx = S_DST;
            end
            S_SRD:   if (wp_ack) state_nx = S_STEP;
            S_SBYTE: if (bp_ack) state_nx = S_DST;
            S_DST: begin
                if (!dst_w_q)                             state_nx = S_DBYTE;
                else if (need_dst)                        state_nx = S_DRD;
                else if (dst_ptr[LB-1:0] == LAST_LANE)    state_nx = S_DWR;
                else                                      state_nx = S_STEP;
            end
            S_DRD:   if (wp_ack) state_nx = S_DST;
            S_DBYTE: if (bp_ack) state_nx = S_STEP;
            S_DWR:   if (wp_ack) state_nx = at_end ? S_DONE : S_STEP;
            S_DONE:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Transfer parameters, pointers and fetch flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_ptr  <= '0;
            dst_ptr  <= '0;
            cnt      <= '0;
            len_q    <= '0;
            src_w_q  <= 1'b0;
            dst_w_q  <= 1'b0;
            need_src <= 1'b1;
            need_dst <= 1'b1;
        end else if (state == S_IDLE) begin
            if (start) begin
                src_ptr  <= src_base;
                dst_ptr  <= dst_base;
                cnt      <= '0;
                len_q    <= byte_count;
                src_w_q  <= src_wordonly;
                dst_w_q  <= dst_wordonly;
                need_src <= 1'b1;
                need_dst <= 1'b1;
            end
        end else begin
            if (state == S_SRD && wp_ack) need_src <= 1'b0;
            if (state == S_DRD && wp_ack) need_dst <= 1'b0;
            if (state == S_DWR && wp_ack) need_dst <= 1'b1;
            if (adv) begin
                src_ptr <= src_ptr + AW'(1);
                dst_ptr <= dst_ptr + AW'(1);
                cnt     <= cnt + LW'(1);
                if (src_w_q && src_ptr[LB-1:0] == LAST_LANE) need_src <= 1'b1;
            end
        end
    end

    // Data buffers: source word, destination word and the byte in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_buf <= '0;
            dst_buf <= '0;
            hold_b  <= '0;
        end else begin
            if (state == S_SRD && wp_ack) src_buf <= wp_rdata;
            if (state == S_DRD && wp_ack) dst_buf <= wp_rdata;
            if (state == S_DST && dst_w_q && !need_dst) dst_buf <= merged;
            if (state == S_SBYTE && bp_ack) hold_b <= bp_rdata;
            if (state == S_STEP && !at_end && src_w_q && !need_src) hold_b <= src_pick;
        end
    end

    // Port drive decoded from the state.
    always_comb begin
        wp_req   = (state == S_SRD) || (state == S_DRD) || (state == S_DWR);
        wp_we    = (state == S_DWR);
        wp_addr  = (state == S_SRD) ? {src_ptr[AW-1:LB], {LB{1'b0}}}
                                    : {dst_ptr[AW-1:LB], {LB{1'b0}}};
        wp_wdata = dst_buf;
        bp_req   = (state == S_SBYTE) || (state == S_DBYTE);
        bp_we    = (state == S_DBYTE);
        bp_addr  = (state == S_SBYTE) ? src_ptr : dst_ptr;
        bp_wdata = hold_b;
        busy     = (state != S_IDLE);
        done     = (state == S_DONE);
    end

endmodule

// File: rtl/bwc_engine_chk.sv
// Protocol and sequencing properties of bwc_engine, bound into every instance.
// Assumes the synchronous active-low reset of the engine.
module bwc_engine_chk #(
    parameter int AW = 16,
    parameter int LW = 16,
    parameter int LB = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [LW-1:0] byte_count,
    input logic          busy,
    input logic          done,
    input logic          wp_req,
    input logic          wp_we,
    input logic          wp_ack,
    input logic [AW-1:0] wp_addr,
    input logic          bp_req,
    input logic          bp_ack,
    input logic [AW-1:0] bp_addr,
    input logic          bp_we,
    input logic          src_w_q,
    input logic          dst_w_q,
    input logic [LW-1:0] len_q
);
    // R11: word request held with stable address until acknowledged
    a_r11_wp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_req && !wp_ack) |=> (wp_req && $stable(wp_addr) && $stable(wp_we)));

    // R11: byte request held with stable address until acknowledged
    a_r11_bp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_req && !bp_ack) |=> (bp_req && $stable(bp_addr) && $stable(bp_we)));

    // R11: never both ports at once
    a_r11_one_port: assert property (@(posedge clk) disable iff (!rst_n)
        !(wp_req && bp_req));

    // R11: word addresses aligned
    a_r11_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        wp_req |-> (wp_addr[LB-1:0] == '0));

    // R8: zero length completes next cycle without traffic
    a_r8_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && byte_count == '0) |=> (done && !wp_req && !bp_req));

    // R9: done is a single-cycle pulse
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: nothing outstanding while done is high
    a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!wp_req && !bp_req));

    // R7: byte writes only for a byte-addressed destination
    a_r7_byte_write_side: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_req && bp_we) |-> !dst_w_q);

    // R7: byte reads only for a byte-addressed source
    a_r7_byte_read_side: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_req && !bp_we) |-> !src_w_q);

    // R5: word writes only for a word-only destination
    a_r5_word_write_side: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_req && wp_we) |-> dst_w_q);

    // R12: start while busy leaves the running length untouched
    a_r12_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(len_q));

endmodule

bind bwc_engine bwc_engine_chk #(.AW(AW), .LW(LW), .LB(LB)) u_bwc_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .byte_count (byte_count),
    .busy       (busy),
    .done       (done),
    .wp_req     (wp_req),
    .wp_we      (wp_we),
    .wp_ack     (wp_ack),
    .wp_addr    (wp_addr),
    .bp_req     (bp_req),
    .bp_ack     (bp_ack),
    .bp_addr    (bp_addr),
    .bp_we      (bp_we),
    .src_w_q    (src_w_q),
    .dst_w_q    (dst_w_q),
    .len_q      (len_q)
);

// File: tb/test_bwc_engine.sv
// Sweep of all start-lane pairs, four side combinations and several lengths.
module test_bwc_engine;
    localparam int AW = 16;
    localparam int LW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] src_base = '0, dst_base = '0;
    logic [LW-1:0] byte_count = '0;
    logic          src_wordonly = 1'b0, dst_wordonly = 1'b0;
    logic          busy, done;
    logic          wp_req, wp_we, wp_ack;
    logic [AW-1:0] wp_addr;
    logic [63:0]   wp_wdata, wp_rdata;
    logic          bp_req, bp_we, bp_ack;
    logic [AW-1:0] bp_addr;
    logic [7:0]    bp_wdata, bp_rdata;

    always #10 clk = ~clk;  // 50 MHz

    bwc_engine #(.AW(AW), .LW(LW), .WORD_W(64)) i_bwc_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .src_base(src_base), .dst_base(dst_base),
        .byte_count(byte_count), .src_wordonly(src_wordonly), .dst_wordonly(dst_wordonly),
        .busy(busy), .done(done),
        .wp_req(wp_req), .wp_we(wp_we), .wp_addr(wp_addr), .wp_wdata(wp_wdata),
        .wp_ack(wp_ack), .wp_rdata(wp_rdata),
        .bp_req(bp_req), .bp_we(bp_we), .bp_addr(bp_addr), .bp_wdata(bp_wdata),
        .bp_ack(bp_ack), .bp_rdata(bp_rdata)
    );

    logic [63:0] wmem [32];
    logic [7:0]  bmem [256];
    logic [7:0]  ew   [256];
    logic [7:0]  eb   [256];
    int wrd_rd, wrd_wr, byt_rd, byt_wr, ovl, mis;
    logic clr_cnt = 1'b0;
    int vectors = 0, fails = 0;

    // Memory model: ack one edge after a request, transaction counters.
    always @(posedge clk) begin
        if (!rst_n || clr_cnt) begin
            wp_ack <= 1'b0; bp_ack <= 1'b0;
            wrd_rd <= 0; wrd_wr <= 0; byt_rd <= 0; byt_wr <= 0; ovl <= 0; mis <= 0;
        end else begin
            wp_ack <= 1'b0;
            bp_ack <= 1'b0;
            if (wp_req && bp_req) ovl <= ovl + 1;
            if (wp_req && wp_addr[2:0] != 3'd0) mis <= mis + 1;
            if (wp_req && !wp_ack) begin
                wp_ack <= 1'b1;
                if (wp_we) begin wmem[wp_addr[7:3]] <= wp_wdata; wrd_wr <= wrd_wr + 1; end
                else begin wp_rdata <= wmem[wp_addr[7:3]]; wrd_rd <= wrd_rd + 1; end
            end
            if (bp_req && !bp_ack) begin
                bp_ack <= 1'b1;
                if (bp_we) begin bmem[bp_addr[7:0]] <= bp_wdata; byt_wr <= byt_wr + 1; end
                else begin bp_rdata <= bmem[bp_addr[7:0]]; byt_rd <= byt_rd + 1; end
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int words_touched(input int base, input int len);
        if (len == 0) return 0;
        return ((base + len - 1) >> 3) - (base >> 3) + 1;
    endfunction

    task automatic run(input bit sw, input bit dw, input int so, input int dd, input int len, input int seed);
        int s, d, bad, guard;
        logic [7:0] b;
        s = 16 + so;
        d = 128 + dd;
        @(negedge clk);
        for (int i = 0; i < 256; i++) begin
            bmem[i] = 8'(i * 37 + seed * 11 + 5);
            wmem[i >> 3][(i & 7) * 8 +: 8] = 8'(i * 53 + seed * 3 + 200);
        end
        for (int i = 0; i < 256; i++) begin
            eb[i] = bmem[i];
            ew[i] = wmem[i >> 3][(i & 7) * 8 +: 8];
        end
        for (int i = 0; i < len; i++) begin
            b = sw ? ew[s + i] : eb[s + i];
            if (dw) ew[d + i] = b; else eb[d + i] = b;
        end
        clr_cnt = 1'b1;
        @(negedge clk);
        clr_cnt = 1'b0;
        src_base = AW'(s); dst_base = AW'(d); byte_count = LW'(len);
        src_wordonly = sw; dst_wordonly = dw;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (len == 0) begin
            check(done === 1'b1, "R8 zero-length done", int'(done), 1);
        end else begin
            // R12: a second start while busy with different parameters
            start = 1'b1; byte_count = LW'(3); dst_base = AW'(0); src_wordonly = ~sw;
            @(negedge clk);
            start = 1'b0;
            guard = 0;
            while (done !== 1'b1 && guard < 2000) begin @(negedge clk); guard++; end
            check(done === 1'b1, "R9 done seen", int'(done), 1);
        end
        // counts at the done cycle: every write already acknowledged
        check(wrd_rd == (sw ? words_touched(s, len) : 0) + (dw ? words_touched(d, len) : 0),
              "R2 R3 word reads", wrd_rd,
              (sw ? words_touched(s, len) : 0) + (dw ? words_touched(d, len) : 0));
        check(wrd_wr == (dw ? words_touched(d, len) : 0), "R5 R6 R9 word writes", wrd_wr,
              dw ? words_touched(d, len) : 0);
        check(byt_rd == (sw ? 0 : len) && byt_wr == (dw ? 0 : len), "R7 byte accesses",
              byt_rd + byt_wr, (sw ? 0 : len) + (dw ? 0 : len));
        check(ovl == 0 && mis == 0, "R11 port overlap/misalign", ovl + mis, 0);
        @(negedge clk);
        check(done === 1'b0 && busy === 1'b0, "R9 single pulse", int'({done, busy}), 0);
        bad = 0;
        for (int i = 0; i < 256; i++) begin
            if (bmem[i] !== eb[i]) bad++;
            if (wmem[i >> 3][(i & 7) * 8 +: 8] !== ew[i]) bad++;
        end
        check(bad == 0, sw ? "R1 R10 R12 data (word source)" :
                        (dw ? "R3 R4 R10 data (word dest)" : "R7 R10 data (byte sides)"), bad, 0);
    endtask

    initial begin
        int lens [6] = '{0, 1, 7, 8, 9, 17};
        int seed = 0;
        repeat (3) @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && wp_req === 1'b0 && bp_req === 1'b0,
              "R9 reset state", int'({busy, done, wp_req, bp_req}), 0);
        rst_n = 1'b1;
        for (int m = 0; m < 4; m++)
            for (int so = 0; so < 8; so++)
                for (int dd = 0; dd < 8; dd++)
                    for (int li = 0; li < 6; li++) begin
                        run(m[0], m[1], so, dd, lens[li], seed);
                        seed++;
                    end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (195000) @(posedge clk);
        vectors++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule